// File: doc/BRIEF.md
# Serial Configuration Stream Loader

This block takes a configuration stream one bit at a time, where a clock-enable strobe qualifies each bit. It walks through a fixed layout. Leading ones are skipped. A four-bit start code follows, then a 24-bit total-length word and a run of four ones. After that come a parameterised number of frames. Each frame has a zero start bit, a parameterised number of payload bits and a four-bit check field. The stream ends with an eight-bit closing code and four don't-care start-up bits. Every frame whose check field matches is presented on a parallel output with a one-cycle valid pulse. The first payload bit received sits in bit 0.

The check field is a fixed pattern, or a nibble taken from a running 16-bit CRC; a static mode input picks which. Any format fault, check mismatch or length disagreement latches an error state. In that state the loader ignores all further bits and drives the active-low `init_n` output low. A low level on `prog_n` returns the loader to idle, ready for a new stream. After the closing code and the four start-up strobes, `done` goes high and stays high until `prog_n` is pulsed.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset, `init_n` is 1, `done` is 0 and `frame_valid` is 0. In idle, any number of 1 bits is skipped, and the first 0 bit is taken as the first bit of the start code.
- R2: The start code is 0,0,1,0 in arrival order. Any other sequence after the first 0 latches the error state.
- R3: The length word is 24 bits, most significant bit first. It is followed by four bits that must all be 1, or the error state is latched.
- R4: Every frame begins with a start bit of 0. A 1 in that position latches the error state.
- R5: For each frame whose check field matches, `frame_data` carries the payload with the first received payload bit in bit 0, and `frame_valid` is high for exactly one cycle: the cycle after the strobe that carried the last check bit. `frame_data` holds its value at all other times.
- R6: The check field is four bits. With `crc_mode`=0 it must be 0,1,1,0 in arrival order. With `crc_mode`=1 it must equal bits 3..0 of a CRC, sent bit 3 first. That CRC uses polynomial x^16+x^15+x^2+1 (0x8005), shifts MSB first, feeds each payload bit XOR crc[15], is cleared by the first start-code bit, is updated only on payload bits, and runs on across frames. A mismatch latches the error state.
- R7: After the last frame, the closing code 0,1,1,1,1,1,1,1 must follow, or the error state is latched. After it, four more strobes raise `done`, which then stays 1 and ignores further bits until `prog_n` goes low.
- R8: The length word must equal the number of bits from the first start-code bit through the last closing-code bit. If it does not, the error state is latched at the last closing-code bit and `done` never rises.
- R9: In the error state, `init_n` is 0, no further `frame_valid` pulse or `done` occurs, and all bits are ignored. A cycle with `prog_n` low returns the loader to idle with `init_n` 1 and `done` 0, after which a new stream loads normally.
- R10: A bit is consumed only in a cycle where `bit_en` is 1. The value of `bit_in` in other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_n | input | 1 | Synchronous active-low restart; returns the loader to idle |
| bit_en | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Serial stream bit |
| crc_mode | input | 1 | Static check mode: 0 fixed pattern, 1 running CRC |
| frame_data | output | FRAME_BITS | Payload of the last accepted frame, first bit in bit 0 |
| frame_valid | output | 1 | One-cycle pulse when `frame_data` is updated |
| init_n | output | 1 | Active-low error flag |
| done | output | 1 | Stream fully loaded, start-up bits consumed |

## Verification
The bench corrupts a single field in each error stream: the start code, a separator bit, the start bit of a middle frame, a check bit of the last frame (in both modes), a closing-code bit, and the length word. It then confirms that exactly the frames before the fault were delivered. A loader that checked too late would pass a corrupted frame. One that failed to freeze would deliver later frames or raise `done`. Streams with gapped strobes and garbage between them catch a loader that samples `bit_in` without `bit_en`. The payload compare catches a reversed bit order. Clean runs that follow each error confirm that `prog_n` really clears the CRC and the counters, and extra bits sent after `done` confirm that the finished state is sticky.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int LEN_W     = 24;
  localparam int PRE_W     = 4;
  localparam int SEP_W     = 4;
  localparam int CHK_W     = 4;
  localparam int POST_W    = 8;
  localparam int STARTUP_N = 4;
  localparam int CRC_W     = 16;

  localparam logic [PRE_W-1:0]  START_CODE = 4'b0010;
  localparam logic [CHK_W-1:0]  FIXED_CHK  = 4'b0110;
  localparam logic [POST_W-1:0] CLOSE_CODE = 8'b0111_1111;
  localparam logic [CRC_W-1:0]  CRC_POLY   = 16'h8005;

  typedef enum logic [3:0] {
    LD_IDLE,
    LD_CODE,
    LD_LEN,
    LD_SEP,
    LD_FSTART,
    LD_FDATA,
    LD_FCHK,
    LD_CLOSE,
    LD_STARTUP,
    LD_DONE,
    LD_FAULT
  } ld_state_e;

endpackage

// File: rtl/cfg_crc_acc.sv
module cfg_crc_acc #(
  parameter int              CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8005,
  parameter int              OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [OUT_W-1:0] crc_low
);

  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;

  always_comb begin
    crc_d = crc_q;
    fb    = crc_q[CRC_W-1] ^ din;
    if (clr) begin
      crc_d = '0;
    end else if (en) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc_low = crc_q[OUT_W-1:0];

  AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_q == '0)); // R6

  AST_CRC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc_q)); // R6

endmodule

// File: rtl/cfg_frame_shift.sv
module cfg_frame_shift #(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en,
  input  logic                  din,
  input  logic                  emit,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic                  frame_valid
);

  logic [FRAME_BITS-1:0] shr_q, shr_d;
  logic [FRAME_BITS-1:0] out_q, out_d;
  logic                  vld_q;

  // first bit in lands in bit 0 once the frame is complete
  always_comb begin
    shr_d = shr_q;
    if (shift_en) shr_d = {din, shr_q[FRAME_BITS-1:1]};
    out_d = emit ? shr_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      shr_q <= shr_d;
      out_q <= out_d;
      vld_q <= emit;
    end
  end

  assign frame_data  = out_q;
  assign frame_valid = vld_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid); // R5

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(frame_data)); // R5

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_loader_pkg::*;
#(
  parameter int FRAME_BITS  = 8,
  parameter int FRAME_COUNT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             crc_mode,
  input  logic [CHK_W-1:0] crc_nib,
  output logic             crc_clr,
  output logic             crc_en,
  output logic             shift_en,
  output logic             emit,
  output logic             done,
  output logic             init_n
);

  localparam int FMAX  = (LEN_W > FRAME_BITS) ? ((LEN_W > POST_W) ? LEN_W : POST_W)
                                              : ((FRAME_BITS > POST_W) ? FRAME_BITS : POST_W);
  localparam int FCW   = $clog2(FMAX);
  localparam int FRW   = (FRAME_COUNT > 1) ? $clog2(FRAME_COUNT) : 1;

  ld_state_e        state_q, state_d;
  logic [FCW-1:0]   fcnt_q, fcnt_d;
  logic [FRW-1:0]   frm_q, frm_d;
  logic [LEN_W-1:0] bcnt_q, bcnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [CHK_W-1:0] chk_nib;
  logic             counting;

  assign chk_nib  = crc_mode ? crc_nib : FIXED_CHK;
  assign counting = state_q inside {LD_CODE, LD_LEN, LD_SEP, LD_FSTART,
                                    LD_FDATA, LD_FCHK, LD_CLOSE};

  always_comb begin
    state_d  = state_q;
    fcnt_d   = fcnt_q;
    frm_d    = frm_q;
    bcnt_d   = bcnt_q;
    len_d    = len_q;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    shift_en = 1'b0;
    emit     = 1'b0;
    if (!prog_n) begin
      state_d = LD_IDLE;
      fcnt_d  = '0;
      frm_d   = '0;
      bcnt_d  = '0;
      len_d   = '0;
    end else if (bit_en) begin
      if (counting) bcnt_d = bcnt_q + LEN_W'(1);
      unique case (state_q)
        LD_IDLE: begin
          if (!bit_in) begin
            state_d = LD_CODE;
            fcnt_d  = FCW'(1);
            bcnt_d  = LEN_W'(1);
            crc_clr = 1'b1;
          end
        end
        LD_CODE: begin
          if (bit_in != START_CODE[~fcnt_q[1:0]]) begin
            state_d = LD_FAULT;
          end else if (fcnt_q == FCW'(PRE_W-1)) begin
            state_d = LD_LEN;
            fcnt_d  = '0;
          end else begin
            fcnt_d = fcnt_q + FCW'(1);
          end
        end
        LD_LEN: begin
          len_d = {len_q[LEN_W-2:0], bit_in};
          if (fcnt_q == FCW'(LEN_W-1)) begin
            state_d = LD_SEP;
            fcnt_d  = '0;
          end else begin
            fcnt_d = fcnt_q + FCW'(1);
          end
        end
        LD_SEP: begin
          if (!bit_in) begin
            state_d = LD_FAULT;
          end else if (fcnt_q == FCW'(SEP_W-1)) begin
            state_d = LD_FSTART;
            fcnt_d  = '0;
          end else begin
            fcnt_d = fcnt_q + FCW'(1);
          end
        end
        LD_FSTART: begin
          if (bit_in) begin
            state_d = LD_FAULT;
          end else begin
            state_d = LD_FDATA;
            fcnt_d  = '0;
          end
        end
        LD_FDATA: begin
          shift_en = 1'b1;
          crc_en   = 1'b1;
          if (fcnt_q == FCW'(FRAME_BITS-1)) begin
            state_d = LD_FCHK;
            fcnt_d  = '0;
          end else begin
            fcnt_d = fcnt_q + FCW'(1);
          end
        end
        LD_FCHK: begin
          if (bit_in != chk_nib[~fcnt_q[1:0]]) begin
            state_d = LD_FAULT;
          end else if (fcnt_q == FCW'(CHK_W-1)) begin
            emit   = 1'b1;
            fcnt_d = '0;
            if (frm_q == FRW'(FRAME_COUNT-1)) begin
              state_d = LD_CLOSE;
              frm_d   = '0;
            end else begin
              state_d = LD_FSTART;
              frm_d   = frm_q + FRW'(1);
            end
          end else begin
            fcnt_d = fcnt_q + FCW'(1);
          end
        end
        LD_CLOSE: begin
          if (bit_in != CLOSE_CODE[~fcnt_q[2:0]]) begin
            state_d = LD_FAULT;
          end else if (fcnt_q == FCW'(POST_W-1)) begin
            fcnt_d  = '0;
            state_d = ((bcnt_q + LEN_W'(1)) == len_q) ? LD_STARTUP : LD_FAULT;
          end else begin
            fcnt_d = fcnt_q + FCW'(1);
          end
        end
        LD_STARTUP: begin
          if (fcnt_q == FCW'(STARTUP_N-1)) begin
            state_d = LD_DONE;
            fcnt_d  = '0;
          end else begin
            fcnt_d = fcnt_q + FCW'(1);
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      fcnt_q  <= '0;
      frm_q   <= '0;
      bcnt_q  <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      fcnt_q  <= fcnt_d;
      frm_q   <= frm_d;
      bcnt_q  <= bcnt_d;
      len_q   <= len_d;
    end
  end

  assign done   = (state_q == LD_DONE);
  assign init_n = (state_q != LD_FAULT);

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LD_FAULT && prog_n) |=> (state_q == LD_FAULT)); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LD_DONE && prog_n) |=> (state_q == LD_DONE)); // R7

  AST_NO_STROBE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && prog_n) |=> ($stable(state_q) && $stable(fcnt_q) && $stable(len_q))); // R10

  AST_RESTART_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |=> (init_n && !done)); // R9

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfg_loader_pkg::*;
#(
  parameter int FRAME_BITS  = 8,
  parameter int FRAME_COUNT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prog_n,
  input  logic                  bit_en,
  input  logic                  bit_in,
  input  logic                  crc_mode,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic                  frame_valid,
  output logic                  init_n,
  output logic                  done
);

  logic rst_meta_q, rst_sync_q;
  logic crc_clr, crc_en, shift_en, emit;
  logic [CHK_W-1:0] crc_nib;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cfg_seq_fsm #(
    .FRAME_BITS (FRAME_BITS),
    .FRAME_COUNT(FRAME_COUNT)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .prog_n  (prog_n),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .crc_mode(crc_mode),
    .crc_nib (crc_nib),
    .crc_clr (crc_clr),
    .crc_en  (crc_en),
    .shift_en(shift_en),
    .emit    (emit),
    .done    (done),
    .init_n  (init_n)
  );

  cfg_crc_acc #(
    .CRC_W(CRC_W),
    .POLY (CRC_POLY),
    .OUT_W(CHK_W)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .clr    (crc_clr),
    .en     (crc_en),
    .din    (bit_in),
    .crc_low(crc_nib)
  );

  cfg_frame_shift #(
    .FRAME_BITS(FRAME_BITS)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .shift_en   (shift_en),
    .din        (bit_in),
    .emit       (emit),
    .frame_data (frame_data),
    .frame_valid(frame_valid)
  );

  AST_DONE_EXCLUDES_FAULT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(done) |-> (init_n && $past(init_n))); // R8

endmodule

// File: tb/tb_cfg_stream_loader.sv
`timescale 1ns/1ps
module tb_cfg_stream_loader;

  localparam int FB = 8;
  localparam int FC = 3;
  localparam int TOTAL_LEN = 4 + 24 + 4 + FC*(1+FB+4) + 8;

  typedef struct packed {
    logic       crc;
    logic [2:0] kind;   // 0 clean,1 code,2 sep,3 start bit,4 check,5 close,6 length
    logic       gap;
    logic [3:0] lead;
    logic       exp_err;
    logic [1:0] exp_frm;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 1'b0, 4'd0, 1'b0, 2'd3},
    '{1'b1, 3'd0, 1'b0, 4'd3, 1'b0, 2'd3},
    '{1'b1, 3'd0, 1'b1, 4'd0, 1'b0, 2'd3},
    '{1'b0, 3'd1, 1'b0, 4'd0, 1'b1, 2'd0},
    '{1'b1, 3'd2, 1'b0, 4'd1, 1'b1, 2'd0},
    '{1'b0, 3'd3, 1'b1, 4'd0, 1'b1, 2'd1},
    '{1'b1, 3'd4, 1'b0, 4'd0, 1'b1, 2'd2},
    '{1'b0, 3'd4, 1'b0, 4'd2, 1'b1, 2'd2},
    '{1'b1, 3'd5, 1'b0, 4'd0, 1'b1, 2'd3},
    '{1'b0, 3'd6, 1'b1, 4'd0, 1'b1, 2'd3},
    '{1'b1, 3'd0, 1'b0, 4'd7, 1'b0, 2'd3}
  };

  logic clk, rst_n, prog_n, bit_en, bit_in, crc_mode;
  logic [FB-1:0] frame_data;
  logic frame_valid, init_n, done;

  int checks, errors, rx_cnt;
  bit finished;
  logic prev_valid;
  logic sbits [0:511];
  int   slen;
  logic [FB-1:0] exp_frames [0:FC-1];

  cfg_stream_loader #(.FRAME_BITS(FB), .FRAME_COUNT(FC)) dut (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .bit_en(bit_en), .bit_in(bit_in),
    .crc_mode(crc_mode), .frame_data(frame_data), .frame_valid(frame_valid),
    .init_n(init_n), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string kind_req(input logic [2:0] k);
    case (k)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R7";
    endcase
  endfunction

  // frame monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_valid) begin
        chk(!prev_valid, "R5", "valid pulse width", 2, 1);
        if (rx_cnt < FC)
          chk(frame_data == exp_frames[rx_cnt], "R5", "frame payload",
              int'(frame_data), int'(exp_frames[rx_cnt]));
        rx_cnt++;
      end
      prev_valid = frame_valid;
    end
  end

  task automatic push(input logic b);
    sbits[slen] = b;
    slen++;
  endtask

  task automatic build(input vec_t t, input int seed);
    logic [15:0] c;
    logic [23:0] len;
    logic [3:0]  nib;
    logic [3:0]  code;
    logic        b;
    slen = 0;
    for (int i = 0; i < 8 + int'(t.lead); i++) push(1'b1);
    code = (t.kind == 3'd1) ? 4'b0110 : 4'b0010;
    for (int i = 3; i >= 0; i--) push(code[i]);
    len = 24'(TOTAL_LEN + ((t.kind == 3'd6) ? 1 : 0));
    for (int i = 23; i >= 0; i--) push(len[i]);
    push(1'b1); push(1'b1); push(t.kind != 3'd2); push(1'b1);
    c = 16'h0000;
    for (int f = 0; f < FC; f++) begin
      exp_frames[f] = FB'(seed*29 + f*71 + 8'h5A);
      push((t.kind == 3'd3) && (f == 1));
      for (int i = 0; i < FB; i++) begin
        b = exp_frames[f][i];
        push(b);
        if (c[15] ^ b) c = (c << 1) ^ 16'h8005;
        else           c = c << 1;
      end
      nib = t.crc ? c[3:0] : 4'b0110;
      for (int k = 3; k >= 0; k--) begin
        b = nib[k];
        if ((t.kind == 3'd4) && (f == FC-1) && (k == 1)) b = ~b;
        push(b);
      end
    end
    for (int i = 0; i < 8; i++) push((i == 0) ? 1'b0 : ((t.kind == 3'd5 && i == 3) ? 1'b0 : 1'b1));
    push(1'b1); push(1'b0); push(1'b1); push(1'b0);
  endtask

  task automatic send(input logic gap);
    for (int i = 0; i < slen; i++) begin
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = sbits[i];
      if (gap) begin
        @(negedge clk);
        bit_en = 1'b0;
        bit_in = ~sbits[i];   // garbage while not strobed: R10
      end
    end
    @(negedge clk);
    bit_en = 1'b0;
    bit_in = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
    @(negedge clk);
    chk(init_n == 1'b1, "R9", "init_n after restart", int'(init_n), 1);
    chk(done == 1'b0, "R9", "done after restart", int'(done), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t t;
    logic [FB-1:0] held;
    checks = 0; errors = 0; rx_cnt = 0; finished = 1'b0; prev_valid = 1'b0;
    rst_n = 1'b0; prog_n = 1'b1; bit_en = 1'b0; bit_in = 1'b0; crc_mode = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(init_n == 1'b1, "R1", "init_n after reset", int'(init_n), 1);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(frame_valid == 1'b0, "R1", "frame_valid after reset", int'(frame_valid), 0);

    // R10: toggling data without strobes must leave the loader idle
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); bit_in = i[0];
    end
    @(negedge clk);
    chk(init_n == 1'b1, "R10", "init_n after unstrobed bits", int'(init_n), 1);

    for (int v = 0; v < NV; v++) begin
      t = VECS[v];
      crc_mode = t.crc;
      rx_cnt = 0;
      build(t, v);
      send(t.gap);
      repeat (3) @(negedge clk);
      chk(rx_cnt == int'(t.exp_frm), "R5", $sformatf("frames delivered vec %0d", v),
          rx_cnt, int'(t.exp_frm));
      chk(init_n == !t.exp_err, t.exp_err ? kind_req(t.kind) : "R6",
          $sformatf("init_n vec %0d", v), int'(init_n), int'(!t.exp_err));
      chk(done == !t.exp_err, t.exp_err ? "R8" : "R7",
          $sformatf("done vec %0d", v), int'(done), int'(!t.exp_err));
      if (!t.exp_err) begin
        // R7: bits after done are ignored
        slen = 0;
        for (int i = 0; i < 8; i++) push(1'b0);
        send(1'b0);
        repeat (2) @(negedge clk);
        chk(done == 1'b1, "R7", "done sticky", int'(done), 1);
        chk(rx_cnt == FC, "R7", "no frames after done", rx_cnt, FC);
      end else begin
        chk(rx_cnt == int'(t.exp_frm), "R9", "frozen after fault", rx_cnt, int'(t.exp_frm));
      end
      restart();
    end

    // R5: payload holds after the pulse
    held = frame_data;
    repeat (10) @(negedge clk);
    chk(frame_data == held, "R5", "frame_data held", int'(frame_data), int'(held));

    // R8: length one short also faults
    t = VECS[0];
    crc_mode = 1'b0;
    rx_cnt = 0;
    build(t, 3);
    for (int i = 0; i < slen; i++) if (i == 8 + 4 + 23) sbits[i] = ~sbits[i];
    send(1'b0);
    repeat (3) @(negedge clk);
    chk(init_n == 1'b0, "R8", "short length faults", int'(init_n), 0);
    chk(done == 1'b0, "R8", "short length no done", int'(done), 0);
    restart();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule